// File: doc/BRIEF.md
# Remote Contact Command Decoder

The block watches eight remote contact lines and turns each new closure into one command strobe for the control processor. A contact is active when it pulls its line low. Each line is first brought into the clock domain and filtered so that contact bounce cannot trigger it. A filtered line fires its command exactly once, when the closure is first accepted. A short tap and a contact held for a long time are both valid requests, and neither one repeats.

Each line has a binding register that software writes through a small write port. The binding holds a command code and a preset index, so any line can be rebound at run time to any command in the set. If several lines are accepted in the same cycle, they are issued one per cycle, lowest line number first.

The block also keeps the unit's operating mode (normal, bypass or tone). An exit-test request acts only while the unit is in bypass or tone. In normal mode it is dropped.

Top module: `rci_decoder_top`

## Requirements
- R1: After reset, `mode_o` is normal (0), `cmd_valid_o` is low, and every line is unbound. Closing an unbound line issues no strobe.
- R2: The command codes on `cmd_code_o` are: 1 user preset, 2 factory preset, 3 bypass, 4 tone, 5 exit test, 6 stereo, 7 mono from left, 8 mono from right, 9 mono from sum, 10 analog input, 11 digital input. Code 0 and codes above 11 leave the line unbound.
- R3: A line must stay low for `DEB_CYCLES` consecutive synchronized cycles before it counts as closed. A low pulse shorter than that, or a bouncing edge, issues no strobe. With a settle time of 4, a steady closure raises `cmd_valid_o` on the 7th rising edge after the line falls.
- R4: An accepted closure raises `cmd_valid_o` for exactly one cycle. Holding the line low issues no further strobe, and releasing it issues nothing. The next closure after a release fires again.
- R5: A write with `wr_en_i` high binds line `wr_sel_i` to `wr_code_i` and `wr_preset_i`. The new binding applies to closures accepted after the write.
- R6: For codes 1 and 2, `cmd_preset_o` carries the bound preset index. For every other code it is 0.
- R7: When several lines are accepted in the same cycle, the lowest-numbered line is issued first. Each of the others follows on a successive cycle in ascending order, and none is lost.
- R8: `mode_o` is encoded as 0 normal, 1 bypass, 2 tone. A bypass strobe sets it to 1 and a tone strobe sets it to 2, in the same cycle as the strobe.
- R9: An exit-test request in bypass or tone mode issues a strobe and returns `mode_o` to 0. In normal mode it issues no strobe and leaves `mode_o` at 0.
- R10: Preset, stereo, mono and input-select commands leave `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| contact_ni | input | 8 | Remote contact lines, low when closed |
| wr_en_i | input | 1 | Binding write enable |
| wr_sel_i | input | 3 | Line whose binding is written |
| wr_code_i | input | 5 | Command code to bind |
| wr_preset_i | input | 3 | Preset index to bind |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 5 | Code of the issued command |
| cmd_preset_o | output | 3 | Preset index of the issued command |
| mode_o | output | 2 | Current operating mode |

## Verification
The main function is driven with four kinds of closure:
- A clean tap, and a long hold followed by a release, which separate edge firing from level firing.
- A bouncing and a too-short closure, which separate real filtering from a bare edge detector.
- Two or three lines closed in the same cycle, which show whether the queue keeps ascending order and issues one per cycle or drops requests.
- Bypass, tone and exit-test sequences started from each mode, which show whether the exit-test condition depends on the current mode.

Rebinding a line between two closures separates a live lookup from a binding latched at reset.

// File: rtl/rci_pkg.sv
package rci_pkg;
  localparam int CODE_W = 5;
  localparam int IDX_W  = 3;

  localparam logic [CODE_W-1:0] CMD_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CMD_USER_PST = 5'd1;
  localparam logic [CODE_W-1:0] CMD_FACT_PST = 5'd2;
  localparam logic [CODE_W-1:0] CMD_BYPASS   = 5'd3;
  localparam logic [CODE_W-1:0] CMD_TONE     = 5'd4;
  localparam logic [CODE_W-1:0] CMD_EXIT     = 5'd5;
  localparam logic [CODE_W-1:0] CMD_STEREO   = 5'd6;
  localparam logic [CODE_W-1:0] CMD_MONO_L   = 5'd7;
  localparam logic [CODE_W-1:0] CMD_MONO_R   = 5'd8;
  localparam logic [CODE_W-1:0] CMD_MONO_SUM = 5'd9;
  localparam logic [CODE_W-1:0] CMD_IN_ANA   = 5'd10;
  localparam logic [CODE_W-1:0] CMD_IN_DIG   = 5'd11;
  localparam logic [CODE_W-1:0] CMD_LAST     = CMD_IN_DIG;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_TONE   = 2'd2
  } mode_e;

  function automatic logic code_bound(input logic [CODE_W-1:0] c);
    return (c != CMD_NONE) && (c <= CMD_LAST);
  endfunction

  function automatic logic code_is_preset(input logic [CODE_W-1:0] c);
    return (c == CMD_USER_PST) || (c == CMD_FACT_PST);
  endfunction
endpackage

// File: rtl/rci_debounce.sv
module rci_debounce #(
  parameter int DEB_CYCLES = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ni,
  output logic press_o
);
  localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_CYCLES - 1);

  logic sync1_q, sync2_q, stable_q, press_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q  <= 1'b1;
      sync2_q  <= 1'b1;
      stable_q <= 1'b1;
      press_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync1_q <= line_ni;
      sync2_q <= sync1_q;
      press_q <= 1'b0;
      if (sync2_q != stable_q) begin
        if (cnt_q == CNT_MAX) begin
          stable_q <= sync2_q;
          press_q  <= stable_q;  // high-to-low accepted
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/rci_map_regs.sv
module rci_map_regs #(
  parameter int N_IN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic [$clog2(N_IN)-1:0] wr_sel_i,
  input  logic [rci_pkg::CODE_W-1:0] wr_code_i,
  input  logic [rci_pkg::IDX_W-1:0] wr_preset_i,
  output logic [N_IN-1:0][rci_pkg::CODE_W-1:0] code_o,
  output logic [N_IN-1:0][rci_pkg::IDX_W-1:0] preset_o,
  output logic [N_IN-1:0] bound_o
);
  localparam int SEL_W = $clog2(N_IN);

  for (genvar g = 0; g < N_IN; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_o[g]   <= rci_pkg::CMD_NONE;
        preset_o[g] <= '0;
      end else if (wr_en_i && wr_sel_i == SEL_W'(g)) begin
        code_o[g]   <= wr_code_i;
        preset_o[g] <= wr_preset_i;
      end
    end
    assign bound_o[g] = rci_pkg::code_bound(code_o[g]);
  end
endmodule

// File: rtl/rci_arbiter.sv
module rci_arbiter #(
  parameter int N_IN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic [N_IN-1:0] req_i,
  output logic gnt_valid_o,
  output logic [$clog2(N_IN)-1:0] gnt_idx_o
);
  localparam int SEL_W = $clog2(N_IN);

  logic [N_IN-1:0] pend_q, all_req, gnt_oh;

  assign all_req = pend_q | req_i;

  always_comb begin
    gnt_idx_o = '0;
    gnt_oh    = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (all_req[i]) begin
        gnt_idx_o = SEL_W'(i);
        gnt_oh    = N_IN'(1) << i;
      end
    end
  end

  assign gnt_valid_o = |all_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= all_req & ~gnt_oh;
  end
endmodule

// File: rtl/rci_decoder_top.sv
module rci_decoder_top #(
  parameter int N_IN       = 8,
  parameter int DEB_CYCLES = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic [N_IN-1:0] contact_ni,
  input  logic wr_en_i,
  input  logic [$clog2(N_IN)-1:0] wr_sel_i,
  input  logic [rci_pkg::CODE_W-1:0] wr_code_i,
  input  logic [rci_pkg::IDX_W-1:0] wr_preset_i,
  output logic cmd_valid_o,
  output logic [rci_pkg::CODE_W-1:0] cmd_code_o,
  output logic [rci_pkg::IDX_W-1:0] cmd_preset_o,
  output logic [1:0] mode_o
);
  import rci_pkg::*;
  localparam int SEL_W = $clog2(N_IN);

  logic [N_IN-1:0] press, bound;
  logic [N_IN-1:0][CODE_W-1:0] map_code;
  logic [N_IN-1:0][IDX_W-1:0] map_pst;
  logic gnt_valid;
  logic [SEL_W-1:0] gnt_idx;

  for (genvar g = 0; g < N_IN; g++) begin : g_line
    rci_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_ni(contact_ni[g]), .press_o(press[g])
    );
  end

  rci_map_regs #(.N_IN(N_IN)) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_code_i(wr_code_i), .wr_preset_i(wr_preset_i),
    .code_o(map_code), .preset_o(map_pst), .bound_o(bound)
  );

  rci_arbiter #(.N_IN(N_IN)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(press & bound),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  mode_e mode_q, mode_d;
  logic valid_q, valid_d;
  logic [CODE_W-1:0] code_q, sel_code;
  logic [IDX_W-1:0] pst_q, sel_pst;

  assign sel_code = map_code[gnt_idx];
  assign sel_pst  = code_is_preset(sel_code) ? map_pst[gnt_idx] : '0;

  always_comb begin
    mode_d  = mode_q;
    valid_d = 1'b0;
    // binding may change while queued; recheck
    if (gnt_valid && code_bound(sel_code)) begin
      valid_d = 1'b1;
      unique case (sel_code)
        CMD_BYPASS: mode_d = MODE_BYPASS;
        CMD_TONE:   mode_d = MODE_TONE;
        CMD_EXIT: begin
          if (mode_q == MODE_NORMAL) valid_d = 1'b0;
          else                       mode_d  = MODE_NORMAL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NORMAL;
      valid_q <= 1'b0;
      code_q  <= CMD_NONE;
      pst_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
      if (valid_d) begin
        code_q <= sel_code;
        pst_q  <= sel_pst;
      end
    end
  end

  assign cmd_valid_o  = valid_q;
  assign cmd_code_o   = code_q;
  assign cmd_preset_o = pst_q;
  assign mode_o       = mode_q;
endmodule

// File: rtl/rci_checker.sv
module rci_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_o,
  input logic [4:0] cmd_code_o,
  input logic [2:0] cmd_preset_o,
  input logic [1:0] mode_o
);
  p_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_code_o >= 5'd1 && cmd_code_o <= 5'd11));

  p_preset_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o != 5'd1 && cmd_code_o != 5'd2) |-> cmd_preset_o == 3'd0);

  p_mode_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  p_bypass_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == 5'd3) |-> mode_o == 2'd1);

  p_tone_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == 5'd4) |-> mode_o == 2'd2);

  p_exit_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_code_o == 5'd5) |-> (mode_o == 2'd0 && $past(mode_o) != 2'd0));

  p_mode_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> (cmd_valid_o && cmd_code_o >= 5'd3 && cmd_code_o <= 5'd5));
endmodule

bind rci_decoder_top rci_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_o(cmd_valid_o),
  .cmd_code_o(cmd_code_o), .cmd_preset_o(cmd_preset_o), .mode_o(mode_o)
);

// File: tb/tb_rci_decoder_top.sv
`timescale 1ns/1ps
module tb_rci_decoder_top;
  localparam int DEB = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] contact_ni = 8'hFF;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [4:0] wr_code_i = '0;
  logic [2:0] wr_preset_i = '0;
  logic cmd_valid_o;
  logic [4:0] cmd_code_o;
  logic [2:0] cmd_preset_o;
  logic [1:0] mode_o;

  always #5 clk = ~clk;

  rci_decoder_top #(.N_IN(8), .DEB_CYCLES(DEB)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .contact_ni(contact_ni), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_code_i(wr_code_i), .wr_preset_i(wr_preset_i),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .cmd_preset_o(cmd_preset_o), .mode_o(mode_o)
  );

  int checks = 0, errors = 0, cyc = 0, ev_n = 0;
  int ev_cyc[64];
  logic [4:0] ev_code[64];
  logic [2:0] ev_pst[64];
  logic [1:0] ev_mode[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni && cmd_valid_o && ev_n < 64) begin
      ev_cyc[ev_n]  = cyc;
      ev_code[ev_n] = cmd_code_o;
      ev_pst[ev_n]  = cmd_preset_o;
      ev_mode[ev_n] = mode_o;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bind_line(input int k, input int code, input int pst);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 3'(k); wr_code_i = 5'(code); wr_preset_i = 3'(pst);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tap(input int k);
    @(negedge clk);
    contact_ni[k] = 1'b0;
    idle(12);
    contact_ni[k] = 1'b1;
    idle(12);
  endtask

  task automatic t_reset();
    chk("R1 valid", cmd_valid_o, 0);
    chk("R1 mode", mode_o, 0);
    ev_n = 0;
    tap(3);
    chk("R1 unbound line count", ev_n, 0);
  endtask

  task automatic t_latency();
    int s, t0;
    bind_line(0, 6, 5);
    s = ev_n;
    @(negedge clk);
    contact_ni[0] = 1'b0;
    t0 = cyc;
    idle(12);
    chk("R3 one strobe", ev_n - s, 1);
    chk("R3 latency", ev_cyc[s] - t0, 7);
    chk("R2 stereo code", ev_code[s], 6);
    chk("R6 preset zero on stereo", ev_pst[s], 0);
    chk("R10 mode kept", ev_mode[s], 0);
    idle(300);
    chk("R4 held no repeat", ev_n - s, 1);
    contact_ni[0] = 1'b1;
    idle(15);
    chk("R4 release silent", ev_n - s, 1);
    tap(0);
    chk("R4 repress fires", ev_n - s, 2);
  endtask

  task automatic t_bounce();
    int s;
    s = ev_n;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); contact_ni[0] = 1'b0;
      idle(2); contact_ni[0] = 1'b1;
    end
    idle(15);
    chk("R3 short pulses ignored", ev_n - s, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); contact_ni[0] = 1'b0;
      idle(2); contact_ni[0] = 1'b1;
    end
    contact_ni[0] = 1'b0;
    idle(15);
    contact_ni[0] = 1'b1;
    idle(15);
    chk("R3 bounce then hold once", ev_n - s, 1);
  endtask

  task automatic t_remap_preset();
    int s;
    bind_line(2, 1, 6);
    s = ev_n;
    tap(2);
    chk("R5 bound count", ev_n - s, 1);
    chk("R2 user preset code", ev_code[s], 1);
    chk("R6 preset index", ev_pst[s], 6);
    bind_line(2, 2, 3);
    tap(2);
    chk("R5 remap code", ev_code[s+1], 2);
    chk("R6 factory index", ev_pst[s+1], 3);
    bind_line(2, 12, 0);
    tap(2);
    chk("R5 code 12 unbound", ev_n - s, 2);
    bind_line(2, 10, 0);
    tap(2);
    chk("R10 analog keeps mode", ev_mode[s+2], 0);
  endtask

  task automatic t_priority();
    int s;
    bind_line(4, 7, 0);
    bind_line(6, 9, 0);
    bind_line(7, 11, 0);
    s = ev_n;
    @(negedge clk);
    contact_ni[7] = 1'b0; contact_ni[4] = 1'b0; contact_ni[6] = 1'b0;
    idle(15);
    contact_ni = 8'hFF;
    idle(15);
    chk("R7 count", ev_n - s, 3);
    chk("R7 first lowest", ev_code[s], 7);
    chk("R7 second", ev_code[s+1], 9);
    chk("R7 third", ev_code[s+2], 11);
    chk("R7 gap1", ev_cyc[s+1] - ev_cyc[s], 1);
    chk("R7 gap2", ev_cyc[s+2] - ev_cyc[s+1], 1);
  endtask

  task automatic t_modes();
    int s;
    bind_line(1, 3, 0);
    bind_line(3, 4, 0);
    bind_line(5, 5, 0);
    s = ev_n;
    tap(5);
    chk("R9 exit in normal dropped", ev_n - s, 0);
    chk("R9 mode still normal", mode_o, 0);
    tap(1);
    chk("R8 bypass mode", mode_o, 1);
    chk("R8 same cycle", ev_mode[s], 1);
    tap(0);
    chk("R10 stereo keeps bypass", mode_o, 1);
    tap(3);
    chk("R8 tone mode", mode_o, 2);
    tap(5);
    chk("R9 exit from tone code", ev_code[ev_n-1], 5);
    chk("R9 exit to normal", mode_o, 0);
    tap(1);
    tap(5);
    chk("R9 exit from bypass", mode_o, 0);
    chk("R9 strobes total", ev_n - s, 6);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_latency();
    t_bounce();
    t_remap_preset();
    t_priority();
    t_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule